// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire serial management link to an external Ethernet PHY. It generates the management clock (MDC) from the system clock and either drives the shared data line (MDIO) or releases it and samples it. The host presents a 10-bit combined PHY/register address, 16 bits of write data, a read/write select and a single-cycle start strobe. The block then runs one complete management frame. At the end of the frame it raises a one-cycle done pulse and, for a read, presents the captured data.

Each frame is built from bit slots, and one slot is one MDC period. MDC is low in the first half of a slot and high in the second half. The master changes its output only at the start of a slot, so the PHY sees each bit on the rising edge. Input bits are sampled in the last system clock of the low half, just before MDC rises.

A write frame has 66 slots, all driven. A read frame has 65 slots. After the address, the master releases the line for one turnaround slot, captures 17 bits, and runs one further released slot before it takes the line back. The half-period of MDC is a parameter. A start strobe is ignored while a frame is in progress.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, mdc_o is low, mdio_o is high, mdio_oe_o is high, done_o and busy_o are low, and rdata_o is zero.
- R2: While busy, MDC has a period of 2*HALF_DIV system clocks. Each period is low for HALF_DIV clocks and then high for HALF_DIV clocks. While idle, MDC stays low.
- R3: Every frame begins with 32 slots in which the master drives 1.
- R4: The preamble is followed by a 4-bit code, driven in this order: 0,1,1,0 for a read and 0,1,0,1 for a write.
- R5: The code is followed by the 10-bit address, most significant bit first.
- R6: A write frame then drives the bits 1,0, then the 16 data bits MSB first, then the bits 1,1. This makes 66 slots and 132*HALF_DIV busy clocks, with the output enable high throughout.
- R7: A read frame drops the output enable from slot 46 to the end of the frame (slot 64), which makes 65 slots. It samples mdio_i in the last low clock of slots 47 to 63, MSB first. After done, rdata_o holds the low 16 of those 17 bits.
- R8: mdio_o changes only at a slot boundary. It stays stable while MDC is high and while MDC is low within a slot.
- R9: done_o is high for exactly one system clock, in the clock after the last slot ends. busy_o falls and the output enable returns high in that same clock.
- R10: A start strobe that arrives while busy_o is high has no effect. The running frame keeps its operation, its bits and its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one frame (accepted only when idle) |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| addr_i | input | 10 | Combined PHY/register address, sent MSB first |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data captured by the last read |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| busy_o | output | 1 | Frame in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto the management line |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Sampled management line |

## Verification
A slot counter that is off by one shows up quickly. The output enable changes in the wrong MDC period, and done arrives a full MDC period early or late. The bench compares every system clock, so these faults are seen within 2*HALF_DIV clocks of the boundary. A wrong shift or frame load corrupts mdio_o within the first 46 slots, and a wrong sample point corrupts rdata_o, which is checked at done. A divider fault distorts MDC in the first slot of any frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS  = 32;
  localparam int CODE_BITS = 4;
  localparam int ADDR_BITS = 10;
  localparam int DATA_BITS = 16;
  localparam int CAP_BITS  = DATA_BITS + 1;
  localparam int HDR_BITS  = PRE_BITS + CODE_BITS + ADDR_BITS;
  localparam int FRAME_W   = HDR_BITS + 2 + DATA_BITS + 2;
  localparam int SLOT_W    = $clog2(FRAME_W + 1);

  localparam logic [CODE_BITS-1:0] CODE_RD = 4'b0110;
  localparam logic [CODE_BITS-1:0] CODE_WR = 4'b0101;

  typedef struct packed {
    logic                 rd;
    logic [ADDR_BITS-1:0] addr;
    logic [DATA_BITS-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic sample_stb,
  output logic slot_end
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CW     = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD - 1);
  localparam logic [CW-1:0] SMP_CNT  = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] HI_CNT   = CW'(HALF_DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                  cnt_d = '0;
    else if (cnt_q == LAST_CNT) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mdc        = run && (cnt_q >= HI_CNT);
  assign sample_stb = run && (cnt_q == SMP_CNT);
  assign slot_end   = run && (cnt_q == LAST_CNT);

  AST_HIGH_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> $past(slot_end)) else $error("MDC fell off slot end"); // R2
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  mdio_req_t            req,
  input  logic                 sample_stb,
  input  logic                 slot_end,
  input  logic                 mdio_in,
  output logic                 busy,
  output logic                 done,
  output logic                 mdio_out,
  output logic                 mdio_oe,
  output logic [DATA_BITS-1:0] rdata
);
  localparam logic [SLOT_W-1:0] REL_SLOT  = SLOT_W'(HDR_BITS);
  localparam logic [SLOT_W-1:0] CAP_FIRST = SLOT_W'(HDR_BITS + 1);
  localparam logic [SLOT_W-1:0] CAP_LAST  = SLOT_W'(HDR_BITS + CAP_BITS);
  localparam logic [SLOT_W-1:0] RD_LAST   = SLOT_W'(HDR_BITS + CAP_BITS + 1);
  localparam logic [SLOT_W-1:0] WR_LAST   = SLOT_W'(FRAME_W - 1);
  localparam int PAD_RD = FRAME_W - HDR_BITS;

  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic                 done_q, done_d;
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic [FRAME_W-1:0]   frame_q, frame_d;
  logic [CAP_BITS-1:0]  cap_q, cap_d;
  logic [DATA_BITS-1:0] rdata_q, rdata_d;
  logic                 in_cap, last_slot;

  assign in_cap    = rd_q && (slot_q >= CAP_FIRST) && (slot_q <= CAP_LAST);
  assign last_slot = slot_q == (rd_q ? RD_LAST : WR_LAST);

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    slot_d  = slot_q;
    frame_d = frame_q;
    cap_d   = cap_q;
    rdata_d = rdata_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        rd_d   = req.rd;
        slot_d = '0;
        if (req.rd)
          frame_d = {{PRE_BITS{1'b1}}, CODE_RD, req.addr, {PAD_RD{1'b1}}};
        else
          frame_d = {{PRE_BITS{1'b1}}, CODE_WR, req.addr, 2'b10, req.wdata, 2'b11};
      end
    end else begin
      if (sample_stb && in_cap)
        cap_d = {cap_q[CAP_BITS-2:0], mdio_in};
      if (slot_end) begin
        if (last_slot) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          if (rd_q) rdata_d = cap_q[DATA_BITS-1:0];
        end else begin
          slot_d  = slot_q + 1'b1;
          frame_d = {frame_q[FRAME_W-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      slot_q  <= '0;
      frame_q <= '1;
      cap_q   <= '0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      slot_q  <= slot_d;
      frame_q <= frame_d;
      cap_q   <= cap_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign mdio_out = busy_q ? frame_q[FRAME_W-1] : 1'b1;
  assign mdio_oe  = !(busy_q && rd_q && (slot_q >= REL_SLOT));

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R9
  AST_OE_LOW_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> busy_q && rd_q) else $error("released outside read"); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(rd_q)) else $error("start taken while busy"); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && $past(busy_q)) else $error("done without frame end"); // R9
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 rd_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  output logic [DATA_BITS-1:0] rdata_o,
  output logic                 done_o,
  output logic                 busy_o,
  output logic                 mdc_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  input  logic                 mdio_i
);
  mdio_req_t req;
  logic      sample_stb, slot_end, busy;

  assign req = '{rd: rd_i, addr: addr_i, wdata: wdata_i};

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy),
    .mdc        (mdc_o),
    .sample_stb (sample_stb),
    .slot_end   (slot_end)
  );

  mdio_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .req        (req),
    .sample_stb (sample_stb),
    .slot_end   (slot_end),
    .mdio_in    (mdio_i),
    .busy       (busy),
    .done       (done_o),
    .mdio_out   (mdio_o),
    .mdio_oe    (mdio_oe_o),
    .rdata      (rdata_o)
  );

  assign busy_o = busy;

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_o) else $error("MDC toggling while idle"); // R2
  AST_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_o && $past(mdc_o) |-> $stable(mdio_o)) else $error("data moved while MDC high"); // R8
endmodule

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;
  localparam int H = 4;

  logic        clk, rst_n, start_i, rd_i, mdio_i;
  logic [9:0]  addr_i;
  logic [15:0] wdata_i, rdata_o;
  logic        done_o, busy_o, mdc_o, mdio_o, mdio_oe_o;

  mdio_frame_master #(.HALF_DIV(H)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  bit          m_busy, m_rd, m_done;
  int          m_tick, m_slot;
  bit          m_bits[$];
  logic [16:0] m_cap;
  logic [15:0] m_rdata;
  logic [16:0] phy_pat;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void build(input bit rd, input logic [9:0] a, input logic [15:0] d);
    m_bits.delete();
    for (int i = 0; i < 32; i++) m_bits.push_back(1'b1);
    if (rd) begin m_bits.push_back(0); m_bits.push_back(1); m_bits.push_back(1); m_bits.push_back(0); end
    else    begin m_bits.push_back(0); m_bits.push_back(1); m_bits.push_back(0); m_bits.push_back(1); end
    for (int i = 9; i >= 0; i--) m_bits.push_back(a[i]);
    if (rd) begin
      for (int i = 0; i < 19; i++) m_bits.push_back(1'b1);
    end else begin
      m_bits.push_back(1); m_bits.push_back(0);
      for (int i = 15; i >= 0; i--) m_bits.push_back(d[i]);
      m_bits.push_back(1); m_bits.push_back(1);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rd = 0; m_tick = 0; m_slot = 0; m_rdata = '0; m_cap = '0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          build(rd_i, addr_i, wdata_i);
          m_busy = 1; m_rd = rd_i; m_tick = 0; m_slot = 0;
        end
      end else begin
        if (m_tick == H - 1 && m_rd && m_slot >= 47 && m_slot <= 63)
          m_cap = {m_cap[15:0], mdio_i};
        if (m_tick == 2 * H - 1) begin
          m_tick = 0;
          m_slot++;
          if (m_slot == m_bits.size()) begin
            m_busy = 0; m_done = 1;
            if (m_rd) m_rdata = m_cap[15:0];
          end
        end else m_tick++;
      end
    end
  end

  // PHY side: drives the captured pattern, one bit per slot, updated away from the edge
  always @(negedge clk) begin
    if (m_busy && m_rd && m_slot >= 47 && m_slot <= 63) mdio_i <= phy_pat[16 - (m_slot - 47)];
    else mdio_i <= 1'b1;
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && cycles > 2) begin
      bit e_mdc, e_oe, e_dat;
      string rq;
      e_mdc = m_busy && (m_tick >= H);
      e_oe  = !(m_busy && m_rd && m_slot >= 46);
      e_dat = m_busy ? m_bits[m_slot] : 1'b1;
      rq = (!m_busy) ? "R8" : (m_slot < 32) ? "R3" : (m_slot < 36) ? "R4" :
           (m_slot < 46) ? "R5" : "R6";
      chk(mdc_o == e_mdc, "R2", "mdc", mdc_o, e_mdc);
      chk(mdio_oe_o == e_oe, "R7", "oe", mdio_oe_o, e_oe);
      if (e_oe) chk(mdio_o == e_dat, rq, "mdio", mdio_o, e_dat);
      chk(done_o == m_done, "R9", "done", done_o, m_done);
      chk(busy_o == m_busy, "R10", "busy", busy_o, m_busy);
      chk(rdata_o == m_rdata, "R7", "rdata", rdata_o, m_rdata);
    end
  end

  task automatic run_frame(input bit rd, input logic [9:0] a, input logic [15:0] d,
                           input logic [16:0] pat, input bit poke_busy, output int len);
    @(negedge clk);
    rd_i = rd; addr_i = a; wdata_i = d; phy_pat = pat; start_i = 1;
    @(negedge clk);
    start_i = 0;
    len = 0;
    while (!done_o) begin
      if (busy_o) len++;
      if (poke_busy && len == 100) begin
        rd_i = !rd; addr_i = ~a; wdata_i = ~d; start_i = 1;
      end else start_i = 0;
      @(negedge clk);
    end
    start_i = 0;
    chk(!busy_o && mdio_oe_o, "R9", "idle at done", {busy_o, mdio_oe_o}, 1);
  endtask

  initial begin
    int len;
    start_i = 0; rd_i = 0; addr_i = '0; wdata_i = '0; phy_pat = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!mdc_o && mdio_o && mdio_oe_o && !done_o && !busy_o && rdata_o == 0,
        "R1", "reset state", {mdc_o, mdio_o, mdio_oe_o, done_o, busy_o}, 5'b01100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_frame(0, 10'h2A5, 16'hC3A5, '0, 0, len);
    chk(len == 132 * H, "R6", "write length", len, 132 * H);
    run_frame(1, 10'h3FF, 16'h0000, 17'h15A3C, 0, len);
    chk(len == 130 * H, "R7", "read length", len, 130 * H);
    chk(rdata_o == 16'h5A3C, "R7", "read data", rdata_o, 16'h5A3C);
    run_frame(1, 10'h000, 16'hFFFF, 17'h0FFFF, 0, len);
    chk(rdata_o == 16'hFFFF, "R7", "read data ones", rdata_o, 16'hFFFF);
    run_frame(0, 10'h001, 16'h0000, '0, 1, len);
    chk(len == 132 * H, "R10", "write length with start while busy", len, 132 * H);
    chk(rdata_o == 16'hFFFF, "R10", "rdata untouched", rdata_o, 16'hFFFF);
    run_frame(1, 10'h155, 16'h1234, 17'h0A5A5, 1, len);
    chk(len == 130 * H, "R10", "read length with start while busy", len, 130 * H);
    chk(rdata_o == 16'hA5A5, "R7", "read data after ignored start", rdata_o, 16'hA5A5);
    repeat (4) @(negedge clk);
    chk(!mdc_o && !busy_o, "R2", "idle mdc low", mdc_o, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule